// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is a synchronous single-port RAM whose word is divided into byte lanes. On every rising clock edge the port may write any subset of lanes, or issue a read of any subset of lanes, at an address taken straight from an input. Access requires two chip selects of opposite polarity to agree. Each lane also has an active-low enable.

Tri-state outputs are represented by a drive-enable bit for each lane. A lane that is not driven shows zero on the data output. The output enable and the sleep input act on that drive vector combinationally, without waiting for a clock edge. A sleep also blocks access at the edge. A parameter sets the read latency to one edge (flow-through) or two edges (pipelined). In pipelined mode the drive vector is delayed together with the data, so the two stay aligned.

Top module: `byte_ram_port`

## Requirements
- R1: An access happens at a rising edge only when `ce_lo_n` is 0, `ce_hi` is 1 and `sleep` is 0. Any other combination writes nothing, and that edge's read yields `rdrive` = 0.
- R2: A selected access with every bit of `lane_en_n` at 1 writes no lane and drives no lane.
- R3: With `rw` = 0 (write), exactly the lanes whose `lane_en_n` bit is 0 store their slice of `wdata`. Lane i is bits [8i+7:8i], and every combination of lanes is allowed. The other lanes keep their contents.
- R4: With `rw` = 1 (read), `rdrive` bit i is 1 exactly for the lanes whose enable was 0. Those lanes carry the stored byte on `rdata`, and every undriven lane shows zero.
- R5: With PIPELINED = 0, read data and `rdrive` are valid after the issuing rising edge and before the next one. They clear at the next edge unless another read is issued.
- R6: With PIPELINED = 1, the same result appears exactly one edge later than in R5, with `rdrive` aligned to its data.
- R7: `oe_n` = 1 forces `rdrive` to 0 and `rdata` to 0 combinationally. Returning `oe_n` to 0 restores the pending read result within the same cycle.
- R8: `sleep` = 1 forces `rdrive` and `rdata` to 0 combinationally, whatever the other inputs are. A write issued while `sleep` is 1 has no effect.
- R9: A read in the cycle after a write to the same address returns the newly written bytes.
- R10: While `rst_n` is 0 and after its release, `rdrive` is 0 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the read-path registers |
| ce_lo_n | input | 1 | Chip select, active low |
| ce_hi | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| lane_en_n | input | LANES | Active-low lane enables |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, forces outputs off and blocks access |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, undriven lanes zero |
| rdrive | output | LANES | Drive enable for each lane |

## Verification
The block is exercised with all 256 lane-enable masks on writes. Each mask is followed by a read under a different, scrambled mask, which exposes a lane written or read in the wrong position or with the wrong polarity. Every chip-select combination that should deselect, and the all-lanes-off mask, are each paired with a full-word write to show that nothing was stored. The output enable and sleep are toggled in the middle of a cycle, with no clock edge, to separate combinational gating from registered gating. Flow-through and pipelined instances run on the same stimulus, so the one-edge latency difference is checked directly.

// File: rtl/bram_pkg.sv
package bram_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } bram_op_e;

  // Port is live only with both chip selects agreeing and no sleep.
  function automatic logic port_live(input logic ce_lo_n, input logic ce_hi,
                                     input logic sleep);
    return !ce_lo_n && ce_hi && !sleep;
  endfunction

  // Number of read-path register stages for the chosen timing.
  function automatic int read_stages(input bit pipelined);
    return pipelined ? 2 : 1;
  endfunction

endpackage

// File: rtl/bram_lane_array.sv
module bram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wr_lane,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = store[addr];
  end

endmodule

// File: rtl/bram_read_pipe.sv
module bram_read_pipe #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int STAGES = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic [LANES-1:0]        sel_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic [LANES-1:0]        sel_out
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    d_q   [STAGES+1];
  logic [LANES-1:0] sel_q [STAGES+1];

  assign d_q[0]   = d_in;
  assign sel_q[0] = sel_in;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[s]   <= '0;
        sel_q[s] <= '0;
      end else begin
        d_q[s]   <= d_q[s-1];
        sel_q[s] <= sel_q[s-1];
      end
    end
  end

  assign d_out   = d_q[STAGES];
  assign sel_out = sel_q[STAGES];

endmodule

// File: rtl/bram_drive_gate.sv
module bram_drive_gate #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        sel,
  input  logic [LANES*LANE_W-1:0] data,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES-1:0]        drive,
  output logic [LANES*LANE_W-1:0] q
);
  logic out_ok;
  assign out_ok = !oe_n && !sleep;
  assign drive  = out_ok ? sel : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign q[g*LANE_W +: LANE_W] = drive[g] ? data[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/byte_ram_port.sv
module byte_ram_port
  import bram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 8,
  parameter int LANE_W    = 8,
  parameter bit PIPELINED = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_lo_n,
  input  logic                    ce_hi,
  input  logic                    rw,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rdrive
);
  localparam int STAGES = read_stages(PIPELINED);
  localparam int DW     = LANES * LANE_W;

  // Named internal events, observed by the bound checker.
  logic             live;
  logic [LANES-1:0] wr_lane_fire;
  logic [LANES-1:0] rd_lane_issue;
  logic             read_issue;
  logic [DW-1:0]    array_word;
  logic [DW-1:0]    pipe_word;
  logic [LANES-1:0] pipe_sel;

  assign live          = port_live(ce_lo_n, ce_hi, sleep);
  assign wr_lane_fire  = (live && bram_op_e'(rw) == OP_WRITE) ? ~lane_en_n : '0;
  assign rd_lane_issue = (live && bram_op_e'(rw) == OP_READ)  ? ~lane_en_n : '0;
  assign read_issue    = |rd_lane_issue;

  bram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .addr    (addr),
    .wdata   (wdata),
    .wr_lane (wr_lane_fire),
    .rd_word (array_word)
  );

  bram_read_pipe #(.LANES(LANES), .LANE_W(LANE_W), .STAGES(STAGES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (array_word),
    .sel_in  (rd_lane_issue),
    .d_out   (pipe_word),
    .sel_out (pipe_sel)
  );

  bram_drive_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_gate (
    .sel   (pipe_sel),
    .data  (pipe_word),
    .oe_n  (oe_n),
    .sleep (sleep),
    .drive (rdrive),
    .q     (rdata)
  );

endmodule

// File: rtl/bram_port_chk.sv
module bram_port_chk #(
  parameter int LANES     = 8,
  parameter int LANE_W    = 8,
  parameter bit PIPELINED = 1'b0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce_lo_n,
  input logic                    ce_hi,
  input logic                    rw,
  input logic                    oe_n,
  input logic                    sleep,
  input logic [LANES-1:0]        lane_en_n,
  input logic [LANES-1:0]        wr_lane_fire,
  input logic                    read_issue,
  input logic [LANES-1:0]        rdrive,
  input logic [LANES*LANE_W-1:0] rdata
);
  logic [LANES*LANE_W-1:0] drive_bits;
  for (genvar g = 0; g < LANES; g++) begin : g_exp
    assign drive_bits[g*LANE_W +: LANE_W] = {LANE_W{rdrive[g]}};
  end

  p_write_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_fire != '0) |-> (!ce_lo_n && ce_hi && !sleep && !rw));

  p_write_lane_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_fire & lane_en_n) == '0);

  p_undriven_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~drive_bits) == '0);

  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rdrive == '0));

  p_sleep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (rdrive == '0 && wr_lane_fire == '0));

  if (PIPELINED) begin : g_pl
    p_pipe_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrive != '0) |-> $past(read_issue, 2));
  end else begin : g_ft
    p_flow_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrive != '0) |-> $past(read_issue));
    p_flow_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrive & $past(lane_en_n)) == '0);
  end

endmodule

bind byte_ram_port bram_port_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .PIPELINED(PIPELINED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_lo_n      (ce_lo_n),
  .ce_hi        (ce_hi),
  .rw           (rw),
  .oe_n         (oe_n),
  .sleep        (sleep),
  .lane_en_n    (lane_en_n),
  .wr_lane_fire (wr_lane_fire),
  .read_issue   (read_issue),
  .rdrive       (rdrive),
  .rdata        (rdata)
);

// File: tb/tb_byte_ram_port.sv
`timescale 1ns/100ps
module tb_byte_ram_port;
  localparam int AW = 4;
  localparam int NL = 8;
  localparam int LW = 8;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_lo_n = 1'b1, ce_hi = 1'b0, rw = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [NL-1:0] lane_en_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_ft, rdata_pl;
  logic [NL-1:0] rdrive_ft, rdrive_pl;

  int vectors = 0;
  int errors  = 0;
  logic [DW-1:0] model [1<<AW];

  always #2 clk = ~clk;

  byte_ram_port #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .PIPELINED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rw(rw),
    .lane_en_n(lane_en_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata_ft), .rdrive(rdrive_ft));

  byte_ram_port #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .PIPELINED(1'b1)) dut_pl (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rw(rw),
    .lane_en_n(lane_en_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata_pl), .rdrive(rdrive_pl));

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_bits(input logic [NL-1:0] m);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NL; i++) if (m[i]) r[i*LW +: LW] = '1;
    return r;
  endfunction

  function automatic logic [DW-1:0] pattern(input int seed);
    logic [DW-1:0] r;
    for (int i = 0; i < NL; i++) r[i*LW +: LW] = 8'((seed * 29 + i * 53 + 7) ^ (seed >> 3));
    return r;
  endfunction

  task automatic go_idle();
    ce_lo_n = 1'b1; ce_hi = 1'b0; rw = 1'b1; lane_en_n = '1; sleep = 1'b0; oe_n = 1'b0;
  endtask

  // Write: applied at negedge, takes effect at the next rising edge.
  task automatic wr(input logic cl, input logic ch, input logic sl,
                    input logic [AW-1:0] a, input logic [NL-1:0] en, input logic [DW-1:0] d);
    @(negedge clk);
    ce_lo_n = cl; ce_hi = ch; sleep = sl; rw = 1'b0; addr = a; lane_en_n = en; wdata = d;
    @(negedge clk);
    if (!cl && ch && !sl)
      model[a] = (model[a] & lane_bits(en)) | (d & ~lane_bits(en));
    go_idle();
  endtask

  // Read: flow-through result checked one edge after issue, pipelined one edge later.
  task automatic rd(input string req, input logic cl, input logic ch,
                    input logic [AW-1:0] a, input logic [NL-1:0] en, input bit tog);
    logic [NL-1:0] exp_dr;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    ce_lo_n = cl; ce_hi = ch; rw = 1'b1; addr = a; lane_en_n = en;
    exp_dr = (!cl && ch) ? ~en : '0;
    exp_d  = model[a] & lane_bits(exp_dr);
    @(negedge clk);
    go_idle();
    #0.2;
    chk({req, " R5 drive"}, DW'(rdrive_ft), DW'(exp_dr));
    chk({req, " R5 data"}, rdata_ft, exp_d);
    chk("R6 not early", DW'(rdrive_pl), '0);
    if (tog) begin
      oe_n = 1'b1; #0.2;
      chk("R7 oe off drive", DW'(rdrive_ft), '0);
      chk("R7 oe off data", rdata_ft, '0);
      oe_n = 1'b0; #0.2;
      chk("R7 oe restore", rdata_ft, exp_d);
      sleep = 1'b1; #0.2;
      chk("R8 sleep off drive", DW'(rdrive_ft), '0);
      sleep = 1'b0; #0.2;
    end
    @(negedge clk);
    #0.2;
    chk({req, " R6 drive"}, DW'(rdrive_pl), DW'(exp_dr));
    chk({req, " R6 data"}, rdata_pl, exp_d);
    chk("R5 clears", DW'(rdrive_ft), '0);
    if (tog) begin
      oe_n = 1'b1; #0.2;
      chk("R7 oe off pipelined", DW'(rdrive_pl), '0);
      oe_n = 1'b0; sleep = 1'b1; #0.2;
      chk("R8 sleep off pipelined", rdata_pl, '0);
      sleep = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < (1 << AW); a++) model[a] = '0;
    go_idle();
    repeat (3) @(negedge clk);
    chk("R10 reset drive ft", DW'(rdrive_ft), '0);
    chk("R10 reset drive pl", DW'(rdrive_pl), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", DW'(rdrive_ft | rdrive_pl), '0);

    // Fill every word through all lanes.
    for (int a = 0; a < (1 << AW); a++) wr(1'b0, 1'b1, 1'b0, AW'(a), '0, pattern(a + 100));
    for (int a = 0; a < (1 << AW); a++) rd("R9 R3 full", 1'b0, 1'b1, AW'(a), '0, a == 3);

    // Every lane mask on writes, scrambled mask on reads.
    for (int m = 0; m < 256; m++) begin
      wr(1'b0, 1'b1, 1'b0, AW'(m), NL'(m), pattern(m));
      rd("R3 R4 mask", 1'b0, 1'b1, AW'(m), NL'((m * 37 + 11) & 255), m % 64 == 5);
    end

    // Deselect combinations: no write, no drive.
    wr(1'b1, 1'b1, 1'b0, 4'd2, '0, '1);
    wr(1'b0, 1'b0, 1'b0, 4'd2, '0, '1);
    wr(1'b1, 1'b0, 1'b0, 4'd2, '0, '1);
    rd("R1 no write", 1'b0, 1'b1, 4'd2, '0, 1'b0);
    rd("R1 ce_lo_n high read", 1'b1, 1'b1, 4'd2, '0, 1'b0);
    rd("R1 ce_hi low read", 1'b0, 1'b0, 4'd2, '0, 1'b0);

    // All lanes disabled.
    wr(1'b0, 1'b1, 1'b0, 4'd4, '1, '1);
    rd("R2 no write", 1'b0, 1'b1, 4'd4, '0, 1'b0);
    rd("R2 no drive", 1'b0, 1'b1, 4'd4, '1, 1'b0);

    // Write attempted during sleep.
    wr(1'b0, 1'b1, 1'b1, 4'd6, '0, '1);
    rd("R8 sleep write", 1'b0, 1'b1, 4'd6, '0, 1'b0);

    // Back-to-back write then read of the same word.
    wr(1'b0, 1'b1, 1'b0, 4'd9, 8'h0F, 64'hA5A5_5A5A_C3C3_3C3C);
    rd("R9 next cycle", 1'b0, 1'b1, 4'd9, '0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule